// File: doc/BRIEF.md
# Polyphase Arbitrary-Ratio Audio Resampler

This block converts a stream of audio samples to an output rate that differs slightly from the input rate. The ratio comes from a fixed-point step value, which an external rate-offset estimator provides. The estimator may compare clocks or watch a buffer's fill level. One output sample is produced for each advance of a phase accumulator by `step`. The integer carry of each advance sets how many fresh input samples must enter the delay line before the next output is due.

The interpolation kernel is stored as a constant bank of `BRANCHES + 1` short FIR branches, each `TAPS` long. The bank is computed when the design elaborates. The high bits of the fractional phase pick a branch. The block evaluates that branch and its upper neighbour on the current delay line, then blends the two results linearly using the low phase bits as the weight. This gives ratios that need not be rational. The latency is bounded by the short branch length. Raising the branch count shrinks the blend error.

Input uses a valid/ready handshake, and `inReady` is high only while samples are still owed. Output is a registered strobe with its sample. At the default parameters (16-bit samples, 32 branches, 8 taps, 8-bit weight, 13-bit phase, step format 2.13), a step of 8192 means a ratio of exactly 1.0.

Top module: `polyphase_resampler`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1. No output appears until TAPS (8) samples have been accepted since reset.
- R2: The phase is FRAC_W = 13 bits and starts at 0. Each output adds the unsigned 2.13 `step` to it. The carry out of bit 12 (0..4) is the number of samples that are accepted before the next output. So output m (from 0) is formed once exactly 8 + floor(m·step/8192) samples have been accepted, at phase (m·step) mod 8192.
- R3: A sample offered while `inReady` is 0, or while `inValid` is 0, is not taken into the delay line.
- R4: Coefficient of branch p (0..32) and tap k has j = k − 4 and B = 32. It equals round(N·2^14 / (2B³)), rounded half away from zero. N is −p³+2p²B−pB² for j=+1, 3p³−5p²B+2B³ for j=0, −3p³+4p²B+pB² for j=−1, and p³−p²B for j=−2. N is 0 for any other j.
- R5: Let d[k] be the k-th most recent accepted sample (d[0] newest). The branch is p = phase[12:8] and the weight is w = phase[7:0]. Then lo = Σ c(p,k)·d[k] and hi = Σ c(p+1,k)·d[k]. The output is floor((256·lo + (hi−lo)·w + 2^21) / 2^22).
- R6: Any R5 result outside the range −32768..32767 is clamped to the nearer limit.
- R7: With `step` = 8192, output m equals input sample m+3 exactly. With input always valid, outputs arrive on every other cycle.
- R8: `outValid` is high for exactly one cycle for each output, one cycle after it is formed. In the forming cycle `inReady` is 0. In any cycle where `inReady` is 1, the next cycle has `outValid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 15 | Phase increment per output, unsigned 2.13 fixed point |
| inValid | input | 1 | Input sample offered |
| inSample | input | 16 | Input sample, signed |
| inReady | output | 1 | Block wants another input sample |
| outValid | output | 1 | Output sample strobe |
| outSample | output | 16 | Output sample, signed |

## Verification
The assertions watch the handshake on every cycle. They check that an output strobe always follows a cycle with `inReady` low, that a cycle with `inReady` high is never followed by a strobe, that no strobe appears before the delay line holds a full window, and that a unity step gives alternating strobes. The numeric content of each output can only be shown by the bench. This covers branch choice, blend weight, rounding, clamping and which input samples were consumed. The bench sweeps steps from fine fractions up to nearly 4.0 and compares each output against an arithmetic model built from the coefficient formula. It uses input gaps and junk data on refused cycles.

// File: rtl/rsmp_pkg.sv
package rsmp_pkg;

  typedef struct packed {
    logic emit;   // form an output this cycle
    logic shift;  // take inSample into the delay line
  } rsmpStrobe_t;

  function automatic longint rsmpRoundDiv(longint num, longint den);
    if (num >= 0) return (num + den / 2) / den;
    return -((-num + den / 2) / den);
  endfunction

  // Cubic interpolating kernel sampled at phase p/nBranch, tap offset j.
  function automatic int rsmpCoef(int phase, int tap, int nBranch, int nTaps, int fracBits);
    longint b;
    longint p;
    longint n;
    int j;
    b = longint'(nBranch);
    p = longint'(phase);
    j = tap - nTaps / 2;
    case (j)
      1:       n = -p*p*p + 2*p*p*b - p*b*b;
      0:       n = 3*p*p*p - 5*p*p*b + 2*b*b*b;
      -1:      n = -3*p*p*p + 4*p*p*b + p*b*b;
      -2:      n = p*p*p - p*p*b;
      default: n = 0;
    endcase
    return int'(rsmpRoundDiv(n <<< fracBits, 2*b*b*b));
  endfunction

endpackage

// File: rtl/rsmp_ctrl.sv
module rsmp_ctrl
  import rsmp_pkg::*;
#(
  parameter int TAPS       = 8,
  parameter int PHASE_W    = 5,
  parameter int BLEND_W    = 8,
  parameter int STEP_INT_W = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic [STEP_INT_W+PHASE_W+BLEND_W-1:0] step,
  input  logic                               inValid,
  output logic                               inReady,
  output rsmpStrobe_t                        strobe,
  output logic [PHASE_W-1:0]                 branch,
  output logic [BLEND_W-1:0]                 blend
);
  localparam int FRAC_W   = PHASE_W + BLEND_W;
  localparam int STEP_W   = STEP_INT_W + FRAC_W;
  localparam int NEED_MAX = (TAPS > (1 << STEP_INT_W)) ? TAPS : (1 << STEP_INT_W);
  localparam int NEED_W   = $clog2(NEED_MAX + 1);

  logic [FRAC_W-1:0]   phaseQ;
  logic [NEED_W-1:0]   needQ;
  logic [STEP_W:0]     sumW;
  logic [STEP_INT_W:0] carryW;

  always_comb begin
    sumW   = {{(STEP_INT_W + 1){1'b0}}, phaseQ} + {1'b0, step};
    carryW = sumW[STEP_W:FRAC_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= '0;
      needQ  <= NEED_W'(TAPS);
    end else if (needQ == '0) begin
      phaseQ <= sumW[FRAC_W-1:0];
      needQ  <= NEED_W'(carryW);
    end else if (inValid) begin
      needQ  <= needQ - 1'b1;
    end
  end

  always_comb begin
    inReady      = (needQ != '0);
    strobe.emit  = (needQ == '0);
    strobe.shift = (needQ != '0) && inValid;
    branch       = phaseQ[FRAC_W-1:BLEND_W];
    blend        = phaseQ[BLEND_W-1:0];
  end

endmodule

// File: rtl/rsmp_datapath.sv
module rsmp_datapath
  import rsmp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int COEF_W   = 16,
  parameter int BRANCHES = 32,
  parameter int TAPS     = 8,
  parameter int BLEND_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  rsmpStrobe_t                strobe,
  input  logic signed [SAMPLE_W-1:0] inSample,
  input  logic [$clog2(BRANCHES)-1:0] branch,
  input  logic [BLEND_W-1:0]         blend,
  output logic                       outValid,
  output logic signed [SAMPLE_W-1:0] outSample
);
  localparam int PHASE_W   = $clog2(BRANCHES);
  localparam int COEF_FRAC = COEF_W - 2;
  localparam int PROD_W    = SAMPLE_W + COEF_W;
  localparam int BR_W      = PROD_W + $clog2(TAPS) + 1;
  localparam int ACC_W     = BR_W + BLEND_W + 2;
  localparam int SHIFT     = COEF_FRAC + BLEND_W;
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(longint'(1) <<< (SHIFT - 1));
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((longint'(1) <<< (SAMPLE_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MINV = ACC_W'(-(longint'(1) <<< (SAMPLE_W - 1)));

  logic signed [SAMPLE_W-1:0] taps    [TAPS];
  logic signed [COEF_W-1:0]   coefTbl [BRANCHES+1][TAPS];

  // Constant coefficient bank, one extra branch for the upper neighbour.
  for (genvar gp = 0; gp <= BRANCHES; gp++) begin : g_branch
    for (genvar gk = 0; gk < TAPS; gk++) begin : g_coef
      localparam int CV = rsmpCoef(gp, gk, BRANCHES, TAPS, COEF_FRAC);
      assign coefTbl[gp][gk] = COEF_W'(CV);
    end
  end

  // Delay line, tap 0 newest.
  for (genvar gk = 0; gk < TAPS; gk++) begin : g_line
    if (gk == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)               taps[gk] <= '0;
        else if (strobe.shift) taps[gk] <= inSample;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)               taps[gk] <= '0;
        else if (strobe.shift) taps[gk] <= taps[gk-1];
      end
    end
  end

  logic [PHASE_W:0]          brHi;
  logic signed [BR_W-1:0]    sumLo, sumHi;
  logic signed [BR_W:0]      diffW;
  logic signed [ACC_W-1:0]   accW, scaledW;
  logic signed [SAMPLE_W-1:0] satW;

  always_comb begin
    brHi  = {1'b0, branch} + 1'b1;
    sumLo = '0;
    sumHi = '0;
    for (int k = 0; k < TAPS; k++) begin
      sumLo = sumLo + BR_W'(PROD_W'(taps[k]) * PROD_W'(coefTbl[branch][k]));
      sumHi = sumHi + BR_W'(PROD_W'(taps[k]) * PROD_W'(coefTbl[brHi][k]));
    end
    diffW   = (BR_W+1)'(sumHi) - (BR_W+1)'(sumLo);
    accW    = (ACC_W'(sumLo) <<< BLEND_W)
            + ACC_W'(diffW) * ACC_W'($signed({1'b0, blend}))
            + RND;
    scaledW = accW >>> SHIFT;
    if (scaledW > MAXV)      satW = MAXV[SAMPLE_W-1:0];
    else if (scaledW < MINV) satW = MINV[SAMPLE_W-1:0];
    else                     satW = scaledW[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      outSample <= '0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) outSample <= satW;
    end
  end

endmodule

// File: rtl/polyphase_resampler.sv
module polyphase_resampler
  import rsmp_pkg::*;
#(
  parameter int SAMPLE_W   = 16,
  parameter int COEF_W     = 16,
  parameter int BRANCHES   = 32,
  parameter int TAPS       = 8,
  parameter int BLEND_W    = 8,
  parameter int STEP_INT_W = 2
) (
  input  logic                                              clk,
  input  logic                                              rst,
  input  logic [STEP_INT_W+$clog2(BRANCHES)+BLEND_W-1:0]    step,
  input  logic                                              inValid,
  input  logic signed [SAMPLE_W-1:0]                        inSample,
  output logic                                              inReady,
  output logic                                              outValid,
  output logic signed [SAMPLE_W-1:0]                        outSample
);
  localparam int PHASE_W = $clog2(BRANCHES);

  rsmpStrobe_t          strobe;
  logic [PHASE_W-1:0]   branch;
  logic [BLEND_W-1:0]   blend;

  rsmp_ctrl #(
    .TAPS(TAPS), .PHASE_W(PHASE_W), .BLEND_W(BLEND_W), .STEP_INT_W(STEP_INT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .step(step), .inValid(inValid), .inReady(inReady),
    .strobe(strobe), .branch(branch), .blend(blend)
  );

  rsmp_datapath #(
    .SAMPLE_W(SAMPLE_W), .COEF_W(COEF_W), .BRANCHES(BRANCHES), .TAPS(TAPS), .BLEND_W(BLEND_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .inSample(inSample), .branch(branch),
    .blend(blend), .outValid(outValid), .outSample(outSample)
  );

endmodule

// File: rtl/polyphase_resampler_chk.sv
module polyphase_resampler_chk #(
  parameter int TAPS   = 8,
  parameter int STEP_W = 15,
  parameter int FRAC_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic [STEP_W-1:0] step,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid
);
  localparam int CNT_W = $clog2(TAPS + 1);
  localparam logic [STEP_W-1:0] UNITY = STEP_W'(1) << FRAC_W;

  logic [CNT_W-1:0] fillCnt;

  always_ff @(posedge clk) begin
    if (rst) fillCnt <= '0;
    else if (inValid && inReady && fillCnt != CNT_W'(TAPS)) fillCnt <= fillCnt + 1'b1;
  end

  p_fill_before_output_r1: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (fillCnt == CNT_W'(TAPS)));

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid);

  p_strobe_after_stall_r8: assert property (@(posedge clk) disable iff (rst)
    !inReady |=> outValid);

  p_ready_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    inReady |=> !outValid);

  p_unity_alternate_r7: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(step) == UNITY) |=> !outValid);

endmodule

bind polyphase_resampler polyphase_resampler_chk #(
  .TAPS(TAPS), .STEP_W(STEP_INT_W + $clog2(BRANCHES) + BLEND_W), .FRAC_W($clog2(BRANCHES) + BLEND_W)
) u_chk (
  .clk(clk), .rst(rst), .step(step), .inValid(inValid), .inReady(inReady), .outValid(outValid)
);

// File: tb/tb_polyphase_resampler.sv
module tb_polyphase_resampler;
  localparam int NTAPS  = 8;
  localparam int DELAY  = NTAPS / 2 - 1;
  localparam int UNITY  = 8192;
  localparam int MRAMP = 0, MRAND = 1, MSQUARE = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [14:0] step = 15'd8192;
  logic inValid = 1'b0;
  logic signed [15:0] inSample = '0;
  logic inReady, outValid;
  logic signed [15:0] outSample;

  int checks = 0, errors = 0, satSeen = 0;
  bit done = 1'b0;
  logic signed [15:0] xs [0:2047];

  always #4 clk = ~clk;

  polyphase_resampler dut (
    .clk(clk), .rst(rst), .step(step), .inValid(inValid), .inSample(inSample),
    .inReady(inReady), .outValid(outValid), .outSample(outSample)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int hashv(int i);
    int v;
    v = i * 32'h9E3779B1;
    v = v ^ (v >>> 15);
    v = v * 32'h85EBCA6B;
    return v ^ (v >>> 13);
  endfunction

  // R4 coefficient rule, B = 32, scale 2^14 over 2B^3 = 65536
  function automatic longint bcoef(int p, int k);
    longint n;
    longint q;
    q = longint'(p);
    case (k - NTAPS / 2)
      1:       n = -q*q*q + 64*q*q - 1024*q;
      0:       n = 3*q*q*q - 160*q*q + 65536;
      -1:      n = -3*q*q*q + 128*q*q + 1024*q;
      -2:      n = q*q*q - 32*q*q;
      default: n = 0;
    endcase
    if (n >= 0) return (n + 2) / 4;
    return -((-n + 2) / 4);
  endfunction

  // R5 model before clamping
  function automatic longint model(int n, int f);
    longint lo, hi, tot;
    int p, w;
    p = f >> 8;
    w = f & 255;
    lo = 0;
    hi = 0;
    for (int k = 0; k < NTAPS; k++) begin
      lo += bcoef(p, k) * longint'(xs[n-1-k]);
      hi += bcoef(p + 1, k) * longint'(xs[n-1-k]);
    end
    tot = lo * 256 + (hi - lo) * longint'(w) + (longint'(1) <<< 21);
    return tot >>> 22;
  endfunction

  task automatic runTest(input int stepV, input int mode, input int nOut, input bit gaps);
    int idx, m, cyc, n, f;
    bit prevAcc, prevReady, prevOut, gap;
    longint pos, raw, expv;
    for (int i = 0; i < 2048; i++) begin
      case (mode)
        MRAMP:   xs[i] = 16'(i * 97 - 20000);
        MSQUARE: xs[i] = ((i >> 2) & 1) ? 16'sh7FFF : 16'sh8000;
        default: xs[i] = 16'(hashv(i + stepV));
      endcase
    end
    step = 15'(stepV);
    inValid = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(outValid == 1'b0, "R1 outValid after reset", outValid, 0);
    chk(inReady == 1'b1, "R1 inReady after reset", inReady, 1);
    idx = 0; m = 0; cyc = 0; pos = 0;
    prevAcc = 1'b0; prevReady = 1'b1; prevOut = 1'b0;
    while (m < nOut && cyc < 20000) begin
      if (prevAcc) idx++;
      if (outValid) begin
        n = NTAPS + int'(pos >>> 13);
        f = int'(pos & 8191);
        chk(prevReady == 1'b0, "R8 inReady low in forming cycle", prevReady, 0);
        chk(idx == n, "R2 samples accepted before output", idx, n);
        raw = model(n, f);
        expv = raw > 32767 ? 32767 : (raw < -32768 ? -32768 : raw);
        if (expv != raw) begin
          satSeen++;
          chk(outSample == expv, "R6 clamped output", outSample, expv);
        end else begin
          chk(outSample == expv, "R5 output value", outSample, expv);
        end
        if (stepV == UNITY) begin
          chk(outSample == xs[m + DELAY], "R7 unity delay", outSample, xs[m + DELAY]);
          if (!gaps && m > 0)
            chk(prevOut == 1'b0, "R7 alternate strobes", prevOut, 0);
        end
        pos += stepV;
        m++;
      end
      if (m == 0) chk(!outValid || idx >= NTAPS, "R1 no early output", idx, NTAPS);
      prevOut = outValid;
      prevReady = inReady;
      gap = gaps && ((hashv(cyc + 777) & 3) == 0);
      inValid = !gap;
      // R3: junk while refused or invalid
      inSample = (inReady && !gap) ? xs[idx] : 16'(16'h5A5A ^ cyc);
      prevAcc = inReady && !gap;
      cyc++;
      @(negedge clk);
    end
    chk(m == nOut, "R2 outputs produced", m, nOut);
  endtask

  initial begin
    runTest(UNITY, MRAMP, 200, 1'b0);
    runTest(UNITY, MRAND, 200, 1'b1);
    runTest(6144, MRAND, 250, 1'b1);
    runTest(8193, MRAND, 250, 1'b0);
    runTest(11223, MRAND, 250, 1'b1);
    runTest(20480, MRAND, 200, 1'b0);
    runTest(4096, MRAND, 250, 1'b1);
    runTest(32767, MRAND, 100, 1'b0);
    runTest(257, MRAND, 300, 1'b1);
    runTest(2731, MSQUARE, 250, 1'b0);
    chk(satSeen > 0, "R6 clamping exercised", satSeen, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule